// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Code Register Bank

This block holds the digital codes for four 8-bit converter channels. Each channel has two stages. The first is a staging register that the register-write port fills. The second is a live register whose value drives the converter code output. Writing a staging register never moves an output. The live registers change only on a transfer event, and a transfer moves every channel that holds new, untransferred data at once, so all outputs update together.

A transfer can come from one of two sources: a one-cycle software load command, or the falling edge of an active-low, asynchronous load strobe. A configuration input picks the source. When it is set, only the strobe can cause a transfer. When it is clear, only the software command can. The strobe passes through a two-flop synchronizer before its falling edge is detected, so a strobe that stays low produces exactly one event. After reset every live register holds zero, and it stays at zero until a write and a transfer have both taken place.

Top module: `quad_dac_regbank`

## Requirements
- R1: During reset and after it is released, every 8-bit field of `dac_code` is zero and every bit of `pending` is zero.
- R2: A write (`wr_en` high at a rising edge) stores `wr_data` in the staging register of the channel selected by `wr_chan` (0 to 3, channel k occupies `dac_code[8k+7:8k]` and `pending[k]`). It sets `pending[k]` and leaves `dac_code` unchanged.
- R3: With `pin_mode_en` low, `sw_load` sampled high at a rising edge copies every pending channel's staging value into its live register at that edge and clears all `pending` bits.
- R4: With `pin_mode_en` high, `sw_load` has no effect on `dac_code` or `pending`.
- R5: With `pin_mode_en` high, a high-to-low transition of `load_n` transfers all pending channels together. `dac_code` changes at the third rising edge that samples `load_n` low: two edges in the synchronizer and one in the live register.
- R6: A `load_n` that stays low yields a single transfer. Data written while it stays low remains pending, and the following rising edge of `load_n` transfers nothing.
- R7: With `pin_mode_en` low, transitions on `load_n` have no effect on `dac_code` or `pending`.
- R8: When a write and a transfer fall in the same cycle, the newly written value reaches the live register and that channel's `pending` bit is left clear.
- R9: A channel whose `pending` bit is clear keeps its live code across a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Staging register write enable |
| wr_chan | input | 2 | Channel index of the write, 0 to 3 |
| wr_data | input | 8 | Code to store in the staging register |
| sw_load | input | 1 | One-cycle software transfer command |
| pin_mode_en | input | 1 | 1: strobe pin is the transfer source; 0: software command is the source |
| load_n | input | 1 | Asynchronous active-low transfer strobe, falling-edge sensitive |
| dac_code | output | 32 | Live codes, channel k in bits [8k+7:8k] |
| pending | output | 4 | Per-channel flag for staged data not yet transferred |

## Verification
The hardest case to reach is a write that arrives in exactly the cycle in which the synchronized strobe edge fires. That cycle lies two clocks after the strobe is first sampled low and cannot be seen at the ports. The stimulus therefore counts clock edges from the moment it lowers `load_n` and issues the write on the second one. It also drives writes while the strobe is held low, to show that a level does not cause a second transfer. Sweeps over all 256 codes check that every channel is independent. Each source is driven while the other source is selected, to check that it is ignored.

// File: rtl/dac_bank_pkg.sv
// Package: shared parameters and types for the four-channel converter code bank.
// Assumes: channel count is a power of two, so the write index decodes without holes.
package dac_bank_pkg;

    localparam int unsigned NUM_CH_DEF      = 4;
    localparam int unsigned CODE_W_DEF      = 8;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Which source produced a transfer in the current cycle.
    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_SW   = 2'd1,
        XFER_PIN  = 2'd2
    } xfer_src_e;

endpackage

// File: rtl/dac_load_sync.sv
// Module: brings the asynchronous active-low load strobe into the clock domain
// and emits a one-cycle pulse on each of its falling edges.
// Assumes: the strobe stays low for at least SYNC_STAGES clocks; the idle level is high.
module dac_load_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n_async,
    output logic fall_pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Synchronizer chain: the first stage samples the raw pin, the rest re-time it.
    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b1;
                    else        sync_q[0] <= strobe_n_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[s] <= 1'b1;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    // History flop: remembers the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // Falling edge: the level was high last cycle and is low now.
    always_comb begin
        fall_pulse = last_q & ~sync_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/dac_load_select.sv
// Module: picks the active transfer source using the configuration bit and
// produces the single transfer strobe shared by all channels.
// Assumes: sw_cmd is a synchronous one-cycle request; pin_fall is already synchronized.
module dac_load_select
    import dac_bank_pkg::*;
(
    input  logic      sw_cmd,
    input  logic      pin_fall,
    input  logic      pin_mode,
    output logic      xfer,
    output xfer_src_e xfer_src
);

    // Source gating: only the configured source can start a transfer.
    always_comb begin
        xfer_src = XFER_NONE;
        if (pin_mode) begin
            if (pin_fall) xfer_src = XFER_PIN;
        end else begin
            if (sw_cmd) xfer_src = XFER_SW;
        end
        xfer = (xfer_src != XFER_NONE);
    end

endmodule

// File: rtl/dac_channel.sv
// Module: one channel of the bank, made of a staging register, a live register
// and a pending flag.
// Assumes: wr_hit and xfer are synchronous, single-cycle qualifiers.
module dac_channel #(
    parameter int unsigned CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_val,
    input  logic              xfer,
    output logic [CODE_W-1:0] live_code,
    output logic              pend
);

    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] stage_next;
    logic              pend_next;

    // Next staging value: a write in this cycle takes priority, so it can be transferred at once.
    always_comb begin
        stage_next = wr_hit ? wr_val : stage_q;
        pend_next  = wr_hit | pend;
    end

    // Staging register: loaded on every write to this channel.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= '0;
        else if (wr_hit) stage_q <= wr_val;
    end

    // Live register: copies staged data only on a transfer while data is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)                live_code <= '0;
        else if (xfer && pend_next) live_code <= stage_next;
    end

    // Pending flag: set by a write, cleared by any transfer (a write in the same cycle goes out with it).
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (xfer) pend <= 1'b0;
        else           pend <= pend_next;
    end

endmodule

// File: rtl/quad_dac_regbank.sv
// Module: top of the double-buffered code bank. It decodes the write port,
// synchronizes the load strobe, selects the transfer source and replicates the channels.
// Assumes: synchronous active-low reset; load_n is asynchronous and idles high.
module quad_dac_regbank
    import dac_bank_pkg::*;
#(
    parameter int unsigned NUM_CH      = NUM_CH_DEF,
    parameter int unsigned CODE_W      = CODE_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [$clog2(NUM_CH)-1:0]            wr_chan,
    input  logic [CODE_W-1:0]                    wr_data,
    input  logic                                 sw_load,
    input  logic                                 pin_mode_en,
    input  logic                                 load_n,
    output logic [NUM_CH*CODE_W-1:0]             dac_code,
    output logic [NUM_CH-1:0]                    pending
);

    localparam int unsigned CH_IDX_W = $clog2(NUM_CH);

    logic              hw_fall;
    logic              load_fire;
    xfer_src_e         load_src;
    logic [NUM_CH-1:0] wr_hit;

    dac_load_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe_n_async (load_n),
        .fall_pulse     (hw_fall)
    );

    dac_load_select sel_i (
        .sw_cmd   (sw_load),
        .pin_fall (hw_fall),
        .pin_mode (pin_mode_en),
        .xfer     (load_fire),
        .xfer_src (load_src)
    );

    // Write decode: one hit line per channel.
    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            wr_hit[k] = wr_en && (wr_chan == CH_IDX_W'(k));
        end
    end

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            dac_channel #(
                .CODE_W (CODE_W)
            ) ch_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_hit    (wr_hit[k]),
                .wr_val    (wr_data),
                .xfer      (load_fire),
                .live_code (dac_code[k*CODE_W +: CODE_W]),
                .pend      (pending[k])
            );
        end
    endgenerate

endmodule

// File: rtl/quad_dac_regbank_chk.sv
// Module: property checker for the code bank, bound to every instance of the top.
// Assumes: it sees the top's ports plus the internal edge pulse and transfer strobe.
module quad_dac_regbank_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CODE_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [$clog2(NUM_CH)-1:0]   wr_chan,
    input logic                        sw_load,
    input logic                        pin_mode_en,
    input logic [NUM_CH*CODE_W-1:0]    dac_code,
    input logic [NUM_CH-1:0]           pending,
    input logic                        hw_fall,
    input logic                        load_fire
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_code == '0) && (pending == '0));

    // R2
    hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_fire) |-> $stable(dac_code));

    // R2
    write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (pending[$past(wr_chan)] == !$past(load_fire)));

    // R3
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_fire) && !$past(wr_en) |-> (pending == '0));

    // R4
    sw_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode_en && sw_load && !hw_fall |=> $stable(dac_code));

    // R6
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_fall |=> !hw_fall);

    // R7
    pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_mode_en && !sw_load |=> $stable(dac_code));

endmodule

bind quad_dac_regbank quad_dac_regbank_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_chan     (wr_chan),
    .sw_load     (sw_load),
    .pin_mode_en (pin_mode_en),
    .dac_code    (dac_code),
    .pending     (pending),
    .hw_fall     (hw_fall),
    .load_fire   (load_fire)
);

// File: tb/quad_dac_regbank_tb_top.sv
// Bench: sweeps codes over all channels and both transfer sources, and keeps
// its own model of the staging, live and pending state.
module quad_dac_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_chan = '0;
    logic [7:0]  wr_data = '0;
    logic        sw_load = 1'b0;
    logic        pin_mode_en = 1'b0;
    logic        load_n = 1'b1;
    logic [31:0] dac_code;
    logic [3:0]  pending;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] m_in  [4];
    logic [7:0] m_dac [4];
    logic [3:0] m_pend;

    always #5 clk = ~clk;

    quad_dac_regbank dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_chan (wr_chan),
        .wr_data (wr_data), .sw_load (sw_load), .pin_mode_en (pin_mode_en),
        .load_n (load_n), .dac_code (dac_code), .pending (pending)
    );

    // Model transfer: every pending channel goes to its live register.
    function automatic void m_xfer();
        for (int k = 0; k < 4; k++) if (m_pend[k]) m_dac[k] = m_in[k];
        m_pend = '0;
    endfunction

    task automatic check(string req);
        logic [31:0] exp_code;
        exp_code = {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
        n_cmp++;
        if (dac_code !== exp_code || pending !== m_pend) begin
            n_bad++;
            $display("FAIL %s: code=%h pend=%b expected code=%h pend=%b",
                     req, dac_code, pending, exp_code, m_pend);
        end
    endtask

    task automatic do_write(input logic [1:0] ch, input logic [7:0] d);
        wr_en = 1'b1; wr_chan = ch; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_in[ch] = d; m_pend[ch] = 1'b1;
    endtask

    task automatic do_sw(input logic [1:0] ch, input logic [7:0] d, input bit with_wr);
        sw_load = 1'b1;
        if (with_wr) begin wr_en = 1'b1; wr_chan = ch; wr_data = d; end
        @(negedge clk);
        sw_load = 1'b0; wr_en = 1'b0;
        if (with_wr) begin m_in[ch] = d; m_pend[ch] = 1'b1; end
        if (!pin_mode_en) m_xfer();
    endtask

    // Strobe pulse of low_cyc clocks; optional write in the cycle the edge fires.
    task automatic do_pin(input int low_cyc, input bit wr_at_fire,
                          input logic [1:0] ch, input logic [7:0] d);
        load_n = 1'b0;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            if (i == low_cyc) load_n = 1'b1;
            if (i == 2) begin
                check("R5 no early transfer");
                if (wr_at_fire) begin wr_en = 1'b1; wr_chan = ch; wr_data = d; end
            end
            if (i == 3) begin
                wr_en = 1'b0;
                if (wr_at_fire) begin m_in[ch] = d; m_pend[ch] = 1'b1; end
                if (pin_mode_en) m_xfer();
                check(wr_at_fire ? "R8 write with strobe" : "R5 strobe transfer");
            end
        end
        for (int i = 4; i <= low_cyc; i++) @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin m_in[k] = '0; m_dac[k] = '0; end
        m_pend = '0;
        repeat (3) @(negedge clk);
        check("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        // R2: a write alone does not move the outputs
        do_write(2'd2, 8'hA5);
        check("R2 write staged only");
        repeat (3) @(negedge clk);
        check("R2 still staged");

        // R7: strobe ignored in software mode
        do_pin(2, 1'b0, 2'd0, 8'h00);
        check("R7 strobe ignored");

        // R3 and R9: software transfer moves only channel 2
        do_sw(2'd0, 8'h00, 1'b0);
        check("R3 R9 sw transfer");

        // Sweep of all codes, software source, one value per channel
        for (int c = 0; c < 256; c++) begin
            for (int k = 0; k < 4; k++) do_write(2'(k), 8'((c * (2*k + 1) + 17*k) & 8'hFF));
            check("R2 sweep staged");
            do_sw(2'd0, 8'h00, 1'b0);
            check("R3 sweep transfer");
        end

        // R8: write coinciding with a software transfer
        do_write(2'd1, 8'h3C);
        do_sw(2'd3, 8'hC3, 1'b1);
        check("R8 write with sw load");

        // Strobe source
        pin_mode_en = 1'b1;
        @(negedge clk);
        do_write(2'd0, 8'h11);
        do_sw(2'd0, 8'h00, 1'b0);
        check("R4 sw ignored in pin mode");
        for (int c = 0; c < 256; c += 15) begin
            do_write(2'(c % 4), 8'(c));
            do_write(2'((c + 1) % 4), 8'(255 - c));
            do_pin(2 + (c % 3), 1'b0, 2'd0, 8'h00);
        end

        // R8: write in the cycle the synchronized edge fires
        do_write(2'd2, 8'h5A);
        do_pin(2, 1'b1, 2'd1, 8'h99);

        // R6: level held low, write during the hold, rising edge does nothing
        load_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 first edge, nothing pending");
        do_write(2'd3, 8'hEE);
        repeat (4) @(negedge clk);
        check("R6 held low no second transfer");
        load_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R6 rising edge no transfer");
        do_pin(3, 1'b0, 2'd0, 8'h00);
        check("R6 next falling edge transfers");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule